// File: doc/BRIEF.md
# Shared Command Bus Scheduler for Narrow Low-Latency Sub-Channels

This block feeds four narrow data sub-channels of a low-latency DRAM memory from one shared address/command bus. Each sub-channel is a separate rank with its own 9-bit data path (8 data bits and 1 parity bit) and its own active-low chip-select. Each sub-channel also has its own request queue. Every access is one self-contained read or write that carries the full address. The device precharges the bank on its own after each access, so the scheduler never issues row, column or precharge commands.

The command bus is double data rate, so one command takes two bus edges, which is one controller cycle. A transfer holds its sub-channel data bus for eight edges, which is `BURST_CYC` = 4 controller cycles. Four data buses can therefore share one command bus. In each cycle the scheduler picks at most one sub-channel in round-robin order. A sub-channel is a candidate only when its queue head targets a bank that has finished its turnaround and its data bus is free. The scheduler then drives the command and the matching chip-select. There is no rolling limit on how many accesses may start in a time window. For every read, a data-valid strobe comes back on that sub-channel a fixed number of cycles after the command.

Top module: `sched_cmd_share`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_valid_o` is 0, all `cs_n_o` bits are 1, all `rd_valid_o` bits are 0 and all `req_ready_o` bits are 1.
- R2: Take a request accepted at a clock edge (valid and ready both high) into an empty queue, where its bank and data bus are free. Its command is on the bus in the cycle after that edge. The command shows the request's write flag, bank and address, and the chip-select of its sub-channel is driven low.
- R3: At most one command is issued per cycle. When `cmd_valid_o` is 1, exactly one `cs_n_o` bit is 0. When `cmd_valid_o` is 0, all `cs_n_o` bits are 1.
- R4: Two commands to the same sub-channel are at least `BURST_CYC` (4) cycles apart. A queue of requests to distinct banks issues exactly 4 cycles apart, with no limit on how many accesses start within any window.
- R5: Two commands to the same bank of the same sub-channel are at least `T_RC` (6) cycles apart. A waiting request issues exactly `T_RC` cycles after the previous access to its bank.
- R6: When more than one sub-channel is eligible, the grant goes to the first eligible one found by searching upward (with wrap-around), starting at the sub-channel just after the one granted most recently. After reset the search starts at sub-channel 0.
- R7: `rd_valid_o[s]` pulses for one cycle exactly `RD_LAT` (5) cycles after the cycle in which a read command (`cmd_we_o`=0) to sub-channel s is on the bus. Writes produce no pulse.
- R8: Each queue holds `QDEPTH` (4) requests. `req_ready_o[s]` is 0 while that queue is full, and a valid request offered while ready is 0 is dropped and never issued.
- R9: Each sub-channel issues its accepted requests in arrival order. Each request is issued exactly once, and no request is issued that was not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NSUB | Per sub-channel request valid |
| req_we_i | input | NSUB | Per sub-channel write flag (1 = write, 0 = read) |
| req_bank_i | input | NSUB*BANK_W | Per sub-channel bank, sub-channel s at bits [s*BANK_W +: BANK_W] |
| req_addr_i | input | NSUB*ADDR_W | Per sub-channel full address, sub-channel s at bits [s*ADDR_W +: ADDR_W] |
| req_ready_o | output | NSUB | Queue of sub-channel s can accept a request |
| cmd_valid_o | output | 1 | A command is on the shared bus this cycle |
| cmd_we_o | output | 1 | Command is a write (1) or a read (0) |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_addr_o | output | ADDR_W | Command full address |
| cs_n_o | output | NSUB | Active-low rank chip-selects, one per sub-channel |
| rd_valid_o | output | NSUB | Read data-valid strobe per sub-channel |

## Verification
A command is due one cycle after its request is accepted, plus any wait for bank turnaround, data-bus occupancy or arbitration. A read strobe is due exactly `RD_LAT` cycles after its command. The bench counts rising edges and samples every output on the falling edge. Each acceptance, each command and each strobe is logged with the cycle number, so expected issue cycles (acceptance + 1, +4 per burst, +6 per bank revisit, rotating grant order) and strobe cycles (command + 5) can be compared exactly. A model queue per sub-channel checks issue order and content, and a due-table indexed by cycle checks every strobe cycle, both where a pulse is expected and where none is.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned ADDR_W = 20;

  typedef struct packed {
    logic              we;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
  } sched_req_t;
endpackage

// File: rtl/sched_req_fifo.sv
`timescale 1ns/1ps
module sched_req_fifo
  import sched_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  sched_req_t din_i,
  input  logic       pop_i,
  output sched_req_t head_o,
  output logic       nonempty_o,
  output logic       ready_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  sched_req_t     mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  cnt;
  logic           push_ok, pop_ok;

  assign ready_o    = (cnt != CW'(DEPTH));
  assign nonempty_o = (cnt != '0);
  assign push_ok    = push_i && ready_o;
  assign pop_ok     = pop_i && nonempty_o;
  assign head_o     = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sched_bank_timer.sv
`timescale 1ns/1ps
module sched_bank_timer
  import sched_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned T_RC      = 6,
  parameter int unsigned BURST_CYC = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [BANK_W-1:0]    issue_bank_i,
  output logic [NUM_BANKS-1:0] bank_ready_o,
  output logic                 bus_free_o
);
  localparam int unsigned TW = $clog2(T_RC + 1);
  localparam int unsigned BW = $clog2(BURST_CYC + 1);

  logic [BW-1:0] bus_cnt;

  // data bus held for BURST_CYC cycles starting with the issue slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             bus_cnt <= '0;
    else if (issue_i)        bus_cnt <= BW'(BURST_CYC - 1);
    else if (bus_cnt != '0)  bus_cnt <= bus_cnt - 1'b1;
  end
  assign bus_free_o = (bus_cnt == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] rc_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        rc_cnt <= '0;
      else if (issue_i && (issue_bank_i == BANK_W'(b)))   rc_cnt <= TW'(T_RC - 1);
      else if (rc_cnt != '0)                              rc_cnt <= rc_cnt - 1'b1;
    end
    assign bank_ready_o[b] = (rc_cnt == '0);
  end
endmodule

// File: rtl/sched_rr_arb.sv
`timescale 1ns/1ps
module sched_rr_arb #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o,
  output logic [N-1:0]  gnt_o
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] cand;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    cand        = '0;
    for (int i = 0; i < N; i++) begin
      cand = IW'((int'(ptr) + i) % N);
      if (!gnt_valid_o && req_i[cand]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = cand;
      end
    end
    gnt_o = '0;
    if (gnt_valid_o) gnt_o[gnt_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr <= '0;
    else if (gnt_valid_o) ptr <= (gnt_idx_o == IW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
  end
endmodule

// File: rtl/sched_rd_strobe.sv
`timescale 1ns/1ps
module sched_rd_strobe #(
  parameter int unsigned RD_LAT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  output logic strobe_o
);
  // one extra stage: input is the grant, command goes out one edge later
  localparam int unsigned SR_LEN = RD_LAT + 1;

  logic [SR_LEN-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '0;
    else         sr <= {sr[SR_LEN-2:0], rd_issue_i};
  end
  assign strobe_o = sr[SR_LEN-1];
endmodule

// File: rtl/sched_cmd_share.sv
`timescale 1ns/1ps
module sched_cmd_share
  import sched_pkg::*;
#(
  parameter int unsigned NSUB      = 4,
  parameter int unsigned QDEPTH    = 4,
  parameter int unsigned T_RC      = 6,
  parameter int unsigned BURST_CYC = 4,
  parameter int unsigned RD_LAT    = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSUB-1:0]          req_valid_i,
  input  logic [NSUB-1:0]          req_we_i,
  input  logic [NSUB*BANK_W-1:0]   req_bank_i,
  input  logic [NSUB*ADDR_W-1:0]   req_addr_i,
  output logic [NSUB-1:0]          req_ready_o,
  output logic                     cmd_valid_o,
  output logic                     cmd_we_o,
  output logic [BANK_W-1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0]        cmd_addr_o,
  output logic [NSUB-1:0]          cs_n_o,
  output logic [NSUB-1:0]          rd_valid_o
);
  localparam int unsigned NUM_BANKS = 2 ** BANK_W;
  localparam int unsigned IW        = (NSUB > 1) ? $clog2(NSUB) : 1;

  sched_req_t             head     [NSUB];
  logic [NUM_BANKS-1:0]   bank_rdy [NSUB];
  logic [NSUB-1:0]        nonempty, bus_free, elig, gnt;
  logic                   gnt_valid;
  logic [IW-1:0]          gnt_idx;

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    sched_req_t din;
    assign din = '{we:   req_we_i[s],
                   bank: req_bank_i[s*BANK_W +: BANK_W],
                   addr: req_addr_i[s*ADDR_W +: ADDR_W]};

    sched_req_fifo #(.DEPTH(QDEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i     (req_valid_i[s]),
      .din_i      (din),
      .pop_i      (gnt[s]),
      .head_o     (head[s]),
      .nonempty_o (nonempty[s]),
      .ready_o    (req_ready_o[s])
    );

    sched_bank_timer #(.NUM_BANKS(NUM_BANKS), .T_RC(T_RC), .BURST_CYC(BURST_CYC)) u_timer (
      .clk_i, .rst_ni,
      .issue_i      (gnt[s]),
      .issue_bank_i (head[s].bank),
      .bank_ready_o (bank_rdy[s]),
      .bus_free_o   (bus_free[s])
    );

    sched_rd_strobe #(.RD_LAT(RD_LAT)) u_strobe (
      .clk_i, .rst_ni,
      .rd_issue_i (gnt[s] && !head[s].we),
      .strobe_o   (rd_valid_o[s])
    );

    assign elig[s] = nonempty[s] && bus_free[s] && bank_rdy[s][head[s].bank];
  end

  sched_rr_arb #(.N(NSUB)) u_arb (
    .clk_i, .rst_ni,
    .req_i       (elig),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx),
    .gnt_o       (gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_we_o    <= 1'b0;
      cmd_bank_o  <= '0;
      cmd_addr_o  <= '0;
      cs_n_o      <= '1;
    end else begin
      cmd_valid_o <= gnt_valid;
      cs_n_o      <= ~gnt;
      if (gnt_valid) begin
        cmd_we_o   <= head[gnt_idx].we;
        cmd_bank_o <= head[gnt_idx].bank;
        cmd_addr_o <= head[gnt_idx].addr;
      end
    end
  end
endmodule

// File: rtl/sched_cmd_share_chk.sv
`timescale 1ns/1ps
module sched_cmd_share_chk
  import sched_pkg::*;
#(
  parameter int unsigned NSUB      = 4,
  parameter int unsigned T_RC      = 6,
  parameter int unsigned BURST_CYC = 4,
  parameter int unsigned RD_LAT    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_o,
  input logic                cmd_we_o,
  input logic [BANK_W-1:0]   cmd_bank_o,
  input logic [NSUB-1:0]     cs_n_o,
  input logic [NSUB-1:0]     rd_valid_o
);
  localparam int unsigned NUM_BANKS = 2 ** BANK_W;
  localparam int unsigned MAXG      = (T_RC > BURST_CYC) ? T_RC : BURST_CYC;
  localparam int unsigned GAP_W     = $clog2(MAXG + 1) + 1;
  localparam logic [GAP_W-1:0] SAT  = '1;

  p_cs_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ($countones(~cs_n_o) == 1));
  p_cs_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cs_n_o == '1));

  for (genvar s = 0; s < NSUB; s++) begin : g_s
    logic              hit;
    logic [GAP_W-1:0]  bus_gap;
    logic [RD_LAT-1:0] rd_sr;

    assign hit = cmd_valid_o && !cs_n_o[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            bus_gap <= SAT;
      else if (hit)           bus_gap <= GAP_W'(1);
      else if (bus_gap != SAT) bus_gap <= bus_gap + 1'b1;
    end

    if (RD_LAT > 1) begin : g_sr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_sr <= '0;
        else         rd_sr <= {rd_sr[RD_LAT-2:0], hit && !cmd_we_o};
      end
    end else begin : g_sr1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_sr <= '0;
        else         rd_sr <= hit && !cmd_we_o;
      end
    end

    p_bus_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |-> (bus_gap >= GAP_W'(BURST_CYC)));
    p_rd_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o[s] == rd_sr[RD_LAT-1]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      logic             bhit;
      logic [GAP_W-1:0] bank_gap;
      assign bhit = hit && (cmd_bank_o == BANK_W'(b));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              bank_gap <= SAT;
        else if (bhit)            bank_gap <= GAP_W'(1);
        else if (bank_gap != SAT) bank_gap <= bank_gap + 1'b1;
      end

      p_bank_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bhit |-> (bank_gap >= GAP_W'(T_RC)));
    end
  end
endmodule

bind sched_cmd_share sched_cmd_share_chk #(
  .NSUB(NSUB), .T_RC(T_RC), .BURST_CYC(BURST_CYC), .RD_LAT(RD_LAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_o(cmd_valid_o), .cmd_we_o(cmd_we_o),
  .cmd_bank_o(cmd_bank_o), .cs_n_o(cs_n_o), .rd_valid_o(rd_valid_o)
);

// File: tb/tb_sched_cmd_share.sv
`timescale 1ns/1ps
module tb_sched_cmd_share;
  import sched_pkg::*;

  localparam int NSUB = 4, QDEPTH = 4, T_RC = 6, BURST = 4, RD_LAT = 5;
  localparam int NB = 2 ** BANK_W;
  localparam logic [ADDR_W-1:0] STRAY = 20'hDEAD5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                    drv_valid [NSUB];
  logic                    drv_we    [NSUB];
  logic [BANK_W-1:0]       drv_bank  [NSUB];
  logic [ADDR_W-1:0]       drv_addr  [NSUB];
  logic [NSUB-1:0]         req_valid, req_we, req_ready, cs_n, rd_valid;
  logic [NSUB*BANK_W-1:0]  req_bank;
  logic [NSUB*ADDR_W-1:0]  req_addr;
  logic                    cmd_valid, cmd_we;
  logic [BANK_W-1:0]       cmd_bank;
  logic [ADDR_W-1:0]       cmd_addr;

  always_comb begin
    for (int s = 0; s < NSUB; s++) begin
      req_valid[s] = drv_valid[s];
      req_we[s]    = drv_we[s];
      req_bank[s*BANK_W +: BANK_W] = drv_bank[s];
      req_addr[s*ADDR_W +: ADDR_W] = drv_addr[s];
    end
  end

  sched_cmd_share #(.NSUB(NSUB), .QDEPTH(QDEPTH), .T_RC(T_RC), .BURST_CYC(BURST), .RD_LAT(RD_LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_bank_i(req_bank), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .cs_n_o(cs_n), .rd_valid_o(rd_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_push = 0, n_issue = 0;
  sched_req_t exp_q [NSUB][$];
  int  hist [NSUB][$];
  int  order_log [$];
  int  last_sub [NSUB];
  int  last_bank [NSUB][NB];
  int  issue_cyc [NSUB];
  int  last_rd [NSUB];
  bit  rd_due [NSUB][64];
  int  s_hit;
  sched_req_t mon_e;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // monitor on falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < NSUB; s++) begin
        if (rd_valid[s] || rd_due[s][cyc % 64])
          chk(rd_valid[s] == rd_due[s][cyc % 64], "R7", $sformatf("rd strobe sub%0d cyc%0d", s, cyc),
              rd_valid[s], rd_due[s][cyc % 64]);
        if (rd_valid[s]) last_rd[s] = cyc;
        rd_due[s][cyc % 64] = 1'b0;
      end
      if (cmd_valid) begin
        chk($countones(~cs_n) == 1, "R3", "chip-selects low", $countones(~cs_n), 1);
        s_hit = -1;
        for (int s = 0; s < NSUB; s++) if (!cs_n[s]) s_hit = s;
        if (cmd_addr == STRAY) chk(1'b0, "R8", "dropped request issued", cmd_addr, 0);
        if (s_hit >= 0) begin
          n_issue++;
          if (exp_q[s_hit].size() == 0) chk(1'b0, "R9", "unexpected command", s_hit, -1);
          else begin
            mon_e = exp_q[s_hit].pop_front();
            chk(mon_e == {cmd_we, cmd_bank, cmd_addr}, "R9", "command content/order",
                {cmd_we, cmd_bank, cmd_addr}, mon_e);
          end
          chk(cyc - last_sub[s_hit] >= BURST, "R4", "sub gap", cyc - last_sub[s_hit], BURST);
          chk(cyc - last_bank[s_hit][cmd_bank] >= T_RC, "R5", "bank gap",
              cyc - last_bank[s_hit][cmd_bank], T_RC);
          last_sub[s_hit] = cyc;
          last_bank[s_hit][cmd_bank] = cyc;
          issue_cyc[s_hit] = cyc;
          hist[s_hit].push_back(cyc);
          order_log.push_back(s_hit);
          if (!cmd_we) rd_due[s_hit][(cyc + RD_LAT) % 64] = 1'b1;
        end
      end else if (cs_n != '1) begin
        chk(1'b0, "R3", "chip-select without command", cs_n, '1);
      end
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic push(int s, bit we, int bank, int addr, output int pcyc);
    while (!req_ready[s]) @(negedge clk);
    drv_valid[s] = 1'b1;
    drv_we[s]    = we;
    drv_bank[s]  = BANK_W'(bank);
    drv_addr[s]  = ADDR_W'(addr);
    exp_q[s].push_back('{we: we, bank: BANK_W'(bank), addr: ADDR_W'(addr)});
    n_push++;
    @(negedge clk);
    pcyc = cyc;
    drv_valid[s] = 1'b0;
  endtask

  task automatic sweep_sub(int s);
    int pc;
    for (int b = 0; b < NB; b++) push(s, b[0], b, s * 4096 + b * 16 + 1, pc);
    for (int b = 0; b < NB / 2; b++) begin
      push(s, 1'b0, b, s * 4096 + b * 16 + 2, pc);
      push(s, 1'b1, b, s * 4096 + b * 16 + 3, pc);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    order_log.delete();
    for (int s = 0; s < NSUB; s++) hist[s].delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int p, p0, p1, p2, p3, pa, pb;
    for (int s = 0; s < NSUB; s++) begin
      drv_valid[s] = 0; drv_we[s] = 0; drv_bank[s] = '0; drv_addr[s] = '0;
      last_sub[s] = -1000; issue_cyc[s] = -1; last_rd[s] = -1;
      for (int b = 0; b < NB; b++) last_bank[s][b] = -1000;
      for (int k = 0; k < 64; k++) rd_due[s][k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_valid == 0 && cs_n == '1 && rd_valid == '0, "R1", "outputs in reset",
        {cmd_valid, cs_n, rd_valid}, {1'b0, 4'hF, 4'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 0 && cs_n == '1 && rd_valid == '0, "R1", "outputs after reset",
        {cmd_valid, cs_n, rd_valid}, {1'b0, 4'hF, 4'h0});
    chk(req_ready == '1, "R1", "ready after reset", req_ready, 4'hF);

    // single read: R2, R7
    push(2, 1'b0, 5, 'h123, p);
    idle(12);
    chk(issue_cyc[2] == p + 1, "R2", "single issue cycle", issue_cyc[2], p + 1);
    chk(last_rd[2] == p + 1 + RD_LAT, "R7", "read strobe cycle", last_rd[2], p + 1 + RD_LAT);

    // five distinct banks on one sub: R4
    clear_logs();
    push(1, 1'b0, 0, 'h1000, p0);
    for (int k = 1; k < 5; k++) push(1, k[0], k, 'h1000 + k, p);
    idle(30);
    chk(hist[1].size() == 5, "R4", "burst count", hist[1].size(), 5);
    for (int k = 0; k < 5 && k < hist[1].size(); k++)
      chk(hist[1][k] == p0 + 1 + BURST * k, "R4", $sformatf("burst issue %0d", k),
          hist[1][k], p0 + 1 + BURST * k);

    // same bank twice: R5
    clear_logs();
    push(0, 1'b0, 7, 'h2000, p0);
    push(0, 1'b1, 7, 'h2001, p);
    idle(20);
    chk(hist[0].size() == 2 && hist[0][1] == p0 + 1 + T_RC, "R5", "bank revisit",
        hist[0].size() == 2 ? hist[0][1] : -1, p0 + 1 + T_RC);

    // all four at once, last grant was sub0: order 1,2,3,0 (R6, R3)
    clear_logs();
    fork
      push(0, 1'b0, 1, 'h3000, p0);
      push(1, 1'b1, 2, 'h3100, p1);
      push(2, 1'b0, 3, 'h3200, p2);
      push(3, 1'b0, 4, 'h3300, p3);
    join
    idle(20);
    for (int k = 0; k < NSUB; k++)
      chk(issue_cyc[(1 + k) % NSUB] == p0 + 1 + k, "R6", $sformatf("rotation slot %0d", k),
          issue_cyc[(1 + k) % NSUB], p0 + 1 + k);

    // two busy subs alternate: 2,0,2,0,... (R6)
    clear_logs();
    fork
      begin push(2, 1'b0, 0, 'h4000, pa); for (int k = 1; k < 4; k++) push(2, 1'b0, k, 'h4000 + k, p); end
      begin push(0, 1'b1, 4, 'h4100, pb); for (int k = 5; k < 8; k++) push(0, 1'b0, k, 'h4100 + k, p); end
    join
    idle(30);
    chk(order_log.size() == 8, "R6", "alternation count", order_log.size(), 8);
    for (int k = 0; k < 8 && k < order_log.size(); k++) begin
      chk(order_log[k] == ((k % 2 == 0) ? 2 : 0), "R6", $sformatf("alternation pick %0d", k),
          order_log[k], (k % 2 == 0) ? 2 : 0);
      chk(((k % 2 == 0) ? hist[2][k/2] : hist[0][k/2]) == pa + 1 + (k % 2) + BURST * (k / 2), "R6",
          $sformatf("alternation cycle %0d", k),
          (k % 2 == 0) ? hist[2][k/2] : hist[0][k/2], pa + 1 + (k % 2) + BURST * (k / 2));
    end

    // backpressure and dropped request: R8
    clear_logs();
    push(3, 1'b0, 9, 'h5000, p0);
    for (int k = 1; k < 5; k++) push(3, 1'b0, 9, 'h5000 + k, p);
    chk(req_ready[3] == 1'b0, "R8", "ready while full", req_ready[3], 0);
    drv_valid[3] = 1'b1; drv_we[3] = 1'b0; drv_bank[3] = 4'd9; drv_addr[3] = STRAY;
    idle(2);
    drv_valid[3] = 1'b0;
    idle(40);
    chk(hist[3].size() == 5, "R8", "issues after drop", hist[3].size(), 5);
    for (int k = 0; k < 5 && k < hist[3].size(); k++)
      chk(hist[3][k] == p0 + 1 + T_RC * k, "R5", $sformatf("same-bank issue %0d", k),
          hist[3][k], p0 + 1 + T_RC * k);

    // sweep every sub x bank, reads and writes mixed: R9, R4, R5, R7
    clear_logs();
    fork
      sweep_sub(0);
      sweep_sub(1);
      sweep_sub(2);
      sweep_sub(3);
    join
    idle(200);
    for (int s = 0; s < NSUB; s++)
      chk(exp_q[s].size() == 0, "R9", $sformatf("sub%0d drained", s), exp_q[s].size(), 0);
    chk(n_issue == n_push, "R9", "issued equals accepted", n_issue, n_push);
    summary();
  end
endmodule